// File: doc/BRIEF.md
# Registered Fan-Out Buffer with Standby

This block is a data register with duplicated outputs. A word of `DATA_W` bits (13 by default) is taken in on a valid edge of a complementary clock pair. The stored word then drives two identical output lanes, A and B, so that two loads can be fed from one register stage. The rising input `clkP` times the capture. The falling input `clkN` must confirm each edge: a capture happens only when `clkN` was high during the low phase of `clkP` and is low when `clkP` rises.

An active-low reset, `rstN`, also acts as a low-power standby control. Its assertion is asynchronous: the register, both lanes and the modelled input-receiver enable all drop at once. Its release passes through a two-stage synchroniser on `clkP`, and the register starts taking clock edges again. The receivers are still settling at that point. Until a settling count of `ACT_CYCLES` rising edges has run out, every captured word is forced to zero. The output `rxEnabled` shows when the receivers are considered on. If the data inputs are held low through the settling window, the outputs stay low the whole time.

Top module: `regfan_buffer`

## Requirements
- R1: `qA` and `qB` always carry the same value, which is the last word the register captured.
- R2: A capture happens only on a rising `clkP` where `clkN` is low at that edge and was high when `clkP` last fell. If `clkN` stays high through the rising edge, or stays low through the falling edge, the edge is ignored and both lanes keep their value.
- R3: While `rstN` is low, `qA`, `qB` and `rxEnabled` are all zero, whatever the clocks and data do. They go to zero as soon as `rstN` falls, without waiting for a clock edge.
- R4: The release of `rstN` reaches the register only after two rising edges of `clkP`. No edge before the second one captures anything.
- R5: `rxEnabled` goes high just after rising edge number `ACT_CYCLES`+2 of `clkP` that follows the release of `rstN`, and then stays high until `rstN` falls.
- R6: An edge that captures while `rxEnabled` is low loads zero. The data input is first taken on the edge after `rxEnabled` rises, so outputs stay low through the settling window even when the data input is high.
- R7: A word present on `dIn` at a valid edge appears on both lanes right after that same edge, one register stage with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkP | input | 1 | True side of the clock pair; its rising edge times capture |
| clkN | input | 1 | Complement side of the clock pair; it qualifies each edge |
| rstN | input | 1 | Active-low reset and standby control, asynchronous on assertion |
| dIn | input | DATA_W | Data word to be registered |
| qA | output | DATA_W | Output lane A |
| qB | output | DATA_W | Output lane B, identical to lane A |
| rxEnabled | output | 1 | High once the modelled input receivers have finished settling |

## Verification
Two functions can act in the same cycle: the end of the receiver-settling count, and the first capture of real data. The bench releases reset with `dIn` held at all ones. It expects zero on both lanes through edge `ACT_CYCLES`+2, the edge at which `rxEnabled` rises, and the full word on the next edge. It then repeats the release with `dIn` held low and expects both lanes to stay low.

A second overlap is reset against an ongoing stream of captures. The bench drops `rstN` between two edges and checks the lanes and `rxEnabled` a fraction of a nanosecond later, before any clock edge could explain the change. Separately, it switches `clkN` into stuck-high and stuck-low patterns and checks that the stored word holds, except on the one edge where the switch still forms a valid pair.

// File: rtl/regfan_pkg.sv
package regfan_pkg;

  // Strobes that the control sends to the datapath each clock.
  typedef struct packed {
    logic capture;  // valid differential edge while the register is active
    logic rxGate;   // receivers settled: pass the data, else force zero
  } fanCtrl_t;

endpackage

// File: rtl/regfan_ctrl.sv
module regfan_ctrl
  import regfan_pkg::*;
#(
  parameter int ACT_CYCLES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clkP,
  input  logic     clkN,
  input  logic     rstN,
  output fanCtrl_t strb,
  output logic     rxEnabled
);

  localparam int CNT_W = $clog2(ACT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ACT_CYCLES);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rstSync;
  logic                   prevN;
  logic                   edgeOk;
  logic [CNT_W-1:0]       settleCnt;

  // Assertion takes effect at once; release walks through the chain.
  always_ff @(posedge clkP or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], 1'b1};
  end
  assign rstSync = syncChain[SYNC_STAGES-1];

  // Level of the complement clock during the low phase of clkP.
  always_ff @(negedge clkP or negedge rstN) begin
    if (!rstN) prevN <= 1'b0;
    else       prevN <= clkN;
  end
  assign edgeOk = prevN & ~clkN;

  // Receiver settling count, started once the register is active.
  always_ff @(posedge clkP or negedge rstN) begin
    if (!rstN)                              settleCnt <= '0;
    else if (rstSync && settleCnt != CNT_DONE) settleCnt <= settleCnt + 1'b1;
  end

  assign rxEnabled    = (settleCnt == CNT_DONE);
  assign strb.capture = rstSync & edgeOk;
  assign strb.rxGate  = rxEnabled;

  // R5: receivers only come up after the register is active.
  a_r5_rx_after_sync: assert property (@(posedge clkP) disable iff (!rstN)
    rxEnabled |-> rstSync);

  // R5: once on, receivers stay on until reset.
  a_r5_rx_sticky: assert property (@(posedge clkP) disable iff (!rstN)
    rxEnabled |=> rxEnabled);

  // R4: the synchronised release precedes the end of settling.
  a_r4_sync_first: assert property (@(posedge clkP) disable iff (!rstN)
    $rose(rstSync) |-> !rxEnabled);

  // R2: a complement clock still high at the edge never captures.
  a_r2_bad_pair: assert property (@(posedge clkP) disable iff (!rstN)
    clkN |-> !strb.capture);

endmodule

// File: rtl/regfan_dp.sv
module regfan_dp
  import regfan_pkg::*;
#(
  parameter int DATA_W = 13,
  parameter int LANES  = 2
) (
  input  logic                         clkP,
  input  logic                         rstN,
  input  fanCtrl_t                     strb,
  input  logic [DATA_W-1:0]            dIn,
  output logic [LANES-1:0][DATA_W-1:0] laneQ
);

  logic [DATA_W-1:0] gatedD;

  assign gatedD = strb.rxGate ? dIn : '0;

  // One register per lane so each lane drives its own load.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clkP or negedge rstN) begin
      if (!rstN)             laneQ[g] <= '0;
      else if (strb.capture) laneQ[g] <= gatedD;
    end
  end

  // R1: lane copies never diverge.
  a_r1_lanes_equal: assert property (@(posedge clkP)
    laneQ[0] == laneQ[LANES-1]);

  // R3: outputs are low while reset is held.
  a_r3_low_in_reset: assert property (@(posedge clkP)
    !rstN |-> laneQ[0] == '0);

  // R2: without a capture strobe the lanes hold.
  a_r2_hold: assert property (@(posedge clkP) disable iff (!rstN)
    !strb.capture |=> $stable(laneQ[0]));

  // R6: a capture before the receivers settle loads zero.
  a_r6_gate_zero: assert property (@(posedge clkP) disable iff (!rstN)
    (strb.capture && !strb.rxGate) |=> laneQ[0] == '0);

endmodule

// File: rtl/regfan_buffer.sv
module regfan_buffer
  import regfan_pkg::*;
#(
  parameter int DATA_W     = 13,
  parameter int ACT_CYCLES = 6
) (
  input  logic              clkP,
  input  logic              clkN,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] qA,
  output logic [DATA_W-1:0] qB,
  output logic              rxEnabled
);

  localparam int LANES = 2;

  fanCtrl_t                     strb;
  logic [LANES-1:0][DATA_W-1:0] laneQ;

  regfan_ctrl #(
    .ACT_CYCLES (ACT_CYCLES),
    .SYNC_STAGES(2)
  ) uCtrl (
    .clkP     (clkP),
    .clkN     (clkN),
    .rstN     (rstN),
    .strb     (strb),
    .rxEnabled(rxEnabled)
  );

  regfan_dp #(
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) uDp (
    .clkP (clkP),
    .rstN (rstN),
    .strb (strb),
    .dIn  (dIn),
    .laneQ(laneQ)
  );

  assign qA = laneQ[0];
  assign qB = laneQ[1];

endmodule

// File: tb/tb_regfan_buffer.sv
`timescale 1ns/1ps
module tb_regfan_buffer;

  localparam int W   = 13;
  localparam int ACT = 6;

  logic         clkP = 1'b0;
  logic         clkN = 1'b1;
  logic         rstN = 1'b0;
  logic [W-1:0] dIn  = '0;
  logic [W-1:0] qA, qB;
  logic         rx;

  int nMode  = 0;  // 0 normal pair, 1 clkN stuck high, 2 clkN stuck low
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [W-1:0] q;
    logic         rx;
    string        req;
  } exp_t;
  exp_t sbq[$];

  regfan_buffer #(.DATA_W(W), .ACT_CYCLES(ACT)) dut (
    .clkP(clkP), .clkN(clkN), .rstN(rstN), .dIn(dIn),
    .qA(qA), .qB(qB), .rxEnabled(rx)
  );

  // 250 MHz; clkN moves 0.1 ns before each clkP edge.
  initial forever begin
    #1.9 clkN = (nMode == 1);
    #0.1 clkP = 1'b1;
    #1.9 clkN = (nMode != 2);
    #0.1 clkP = 1'b0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: sets data at the falling edge and queues the expectation.
  task automatic drive(int mode, logic [W-1:0] d, logic [W-1:0] eq,
                       logic erx, string req);
    @(negedge clkP);
    nMode = mode;
    dIn   = d;
    sbq.push_back('{q: eq, rx: erx, req: req});
  endtask

  // Monitor: compares 1 ns after each rising edge.
  always @(posedge clkP) begin
    exp_t e;
    #1;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      chk({e.req, " qA"}, 32'(qA), 32'(e.q));
      chk({e.req, " R1 qB"}, 32'(qB), 32'(e.q));
      chk({e.req, " R5 rxEnabled"}, 32'(rx), 32'(e.rx));
    end
  end

  // Release reset just after a falling edge; dVal held through the window.
  task automatic release_window(logic [W-1:0] dVal, string req);
    for (int k = 1; k <= ACT + 3; k++) begin
      @(negedge clkP);
      nMode = 0;
      dIn   = dVal;
      if (k == 1) begin
        #0.5;
        rstN = 1'b1;
      end
      sbq.push_back('{q: (k >= ACT + 3) ? dVal : '0,
                      rx: (k >= ACT + 2),
                      req: (k <= 2) ? {req, " R4 sync"} : {req, " R6 window"}});
    end
  endtask

  initial begin
    logic [W-1:0] held;
    logic [W-1:0] lfsr;
    logic [W-1:0] pats [4];

    // R3: reset held, data toggling
    drive(0, 13'h1ABC, '0, 1'b0, "R3 reset");
    drive(0, 13'h0F0F, '0, 1'b0, "R3 reset");
    drive(0, 13'h1FFF, '0, 1'b0, "R3 reset");

    // R4 R5 R6: release with data high
    release_window('1, "R6 high data");
    held = '1;

    // R7 R1: distinct patterns
    pats[0] = 13'h0000; pats[1] = 13'h1FFF;
    pats[2] = 13'h1555; pats[3] = 13'h0AAA;
    for (int i = 0; i < 4; i++) drive(0, pats[i], pats[i], 1'b1, "R7 pattern");
    for (int i = 0; i < W; i++) drive(0, W'(1) << i, W'(1) << i, 1'b1, "R7 walk");
    lfsr = 13'h0B3D;
    for (int i = 0; i < 16; i++) begin
      lfsr = {lfsr[11:0], lfsr[12] ^ lfsr[3] ^ lfsr[2] ^ lfsr[0]};
      drive(0, lfsr, lfsr, 1'b1, "R7 lfsr");
    end
    held = lfsr;

    // R2: clkN stuck high, every edge ignored
    drive(1, 13'h0123, held, 1'b1, "R2 stuck high");
    drive(1, 13'h1456, held, 1'b1, "R2 stuck high");
    drive(1, 13'h0789, held, 1'b1, "R2 stuck high");
    drive(0, 13'h0ACE, 13'h0ACE, 1'b1, "R2 pair restored");
    held = 13'h0ACE;

    // R2: clkN stuck low, first edge still a valid pair
    drive(2, 13'h1BDF, 13'h1BDF, 1'b1, "R2 stuck low first");
    held = 13'h1BDF;
    drive(2, 13'h0246, held, 1'b1, "R2 stuck low");
    drive(2, 13'h1357, held, 1'b1, "R2 stuck low");
    drive(0, 13'h0864, held, 1'b1, "R2 low phase missed");
    drive(0, 13'h1975, 13'h1975, 1'b1, "R2 pair restored");

    // R3: asynchronous assertion between edges
    @(negedge clkP);
    #0.5;
    rstN = 1'b0;
    #0.1;
    chk("R3 async qA", 32'(qA), 32'h0);
    chk("R3 async qB", 32'(qB), 32'h0);
    chk("R3 async rxEnabled", 32'(rx), 32'h0);
    drive(0, 13'h1FFF, '0, 1'b0, "R3 reset");
    drive(0, 13'h1FFF, '0, 1'b0, "R3 reset");

    // R6: release with data low, outputs stay low, then data flows
    release_window('0, "R6 low data");
    drive(0, 13'h1234, 13'h1234, 1'b1, "R7 after window");
    drive(0, 13'h0DCB, 13'h0DCB, 1'b1, "R7 after window");

    @(negedge clkP);
    @(negedge clkP);
    if (sbq.size() != 0) chk("scoreboard drained", 32'(sbq.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule